// File: doc/BRIEF.md
# Timer Interrupt Priority Vector Encoder

This block sits between a timer's eleven interrupt sources and the interrupt controller of the processor. Each clock cycle it looks at the sources that are both pending and enabled and chooses one winner. A fixed order decides the winner. It then forms an 8-bit vector and the byte address of that vector's table entry. The upper nibble of the vector comes from a programmable base field. The lower nibble comes from the code of the winning source.

A 4-bit adjust field can promote one source above all the others. A promoted source that is pending wins over every other pending source, and its vector takes low nibble 0. The remaining sources keep their order and their codes. This lets software make one channel the most urgent without moving the vector table. The outputs are registered, so they show the inputs of the previous clock. When no source is pending, the request line is low and the last vector stays on the outputs.

Top module: `tv_prio_vec`

## Requirements
- R1: While synchronous reset is high, req_o, sel_o, vec_o and addr_o are all zero at the next clock edge.
- R2: req_o is high one clock after any bit of pend_i is high, and low one clock after pend_i is all zero.
- R3: Source bit k of pend_i carries code k+1, so codes run from 1 to 11. Without promotion, the pending source with the smallest code wins, and sel_o shows its code one clock later.
- R4: vec_o is base_i (sampled in the same cycle as the winner) in bits 7:4 and the winner's low nibble in bits 3:0.
- R5: addr_o equals twice vec_o: 9 bits, vec_o shifted left by one with bit 0 zero. For example, vector 0x46 gives 0x8C.
- R6: If adj_i holds a code from 1 to 11 and that source is pending, it wins over all other pending sources. sel_o shows that code and the low nibble of vec_o is 0.
- R7: An adj_i of 0 or 12 to 15, or an adj_i naming a source that is not pending, leaves the winner, sel_o and vec_o exactly as R3 and R4 give them.
- R8: In a cycle with no pending source, sel_o, vec_o and addr_o keep their previous values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | 11 | Pending-and-enabled bit per source, bit k = code k+1 |
| base_i | input | 4 | Vector base, upper vector nibble |
| adj_i | input | 4 | Code of the source to promote, 0 for none |
| req_o | output | 1 | Some source was pending in the previous cycle |
| sel_o | output | 4 | Code of the winning source |
| vec_o | output | 8 | Interrupt vector |
| addr_o | output | 9 | Vector table address, twice the vector |

## Verification
The bench builds the block with its default parameters: eleven sources, a 4-bit base and the promotion variant turned on. With these values every source code from 1 to 11 and every adjust value from 0 to 15 can be reached. This covers the out-of-range adjust codes 12 to 15 as well as promoting the last source, code 11. The 4-bit base reaches 0xF, so the top address bit of addr_o is exercised.

// File: rtl/tv_pkg.sv
package tv_pkg;
   localparam int TV_CODE_W = 4;
   typedef logic [TV_CODE_W-1:0] tv_code_t;
endpackage

// File: rtl/tv_fixed_pick.sv
module tv_fixed_pick import tv_pkg::*; #(
   parameter int SRC_CNT = 11
) (
   input  logic [SRC_CNT-1:0] pend,
   output logic               hit,
   output tv_code_t           code
);
   // Scan from the lowest priority upward; the last match is the winner.
   always_comb begin
      hit  = |pend;
      code = '0;
      for (int i = SRC_CNT - 1; i >= 0; i--) begin
         if (pend[i]) code = tv_code_t'(i + 1);
      end
   end
endmodule

// File: rtl/tv_promote.sv
module tv_promote import tv_pkg::*; #(
   parameter int SRC_CNT = 11,
   parameter bit ADJ_EN  = 1'b1
) (
   input  logic [SRC_CNT-1:0] pend,
   input  tv_code_t           adj,
   output logic               hit
);
   generate
      if (ADJ_EN) begin : g_adj
         always_comb begin
            hit = 1'b0;
            for (int i = 0; i < SRC_CNT; i++) begin
               if (pend[i] && (adj == tv_code_t'(i + 1))) hit = 1'b1;
            end
         end
      end else begin : g_noadj
         logic unused_in;
         assign unused_in = ^{pend, adj};
         assign hit       = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tv_vec_form.sv
module tv_vec_form import tv_pkg::*; #(
   parameter int BASE_W = 4,
   localparam int VEC_W = BASE_W + TV_CODE_W
) (
   input  logic [BASE_W-1:0] base,
   input  tv_code_t          code,
   input  logic              promo,
   output logic [VEC_W-1:0]  vec,
   output logic [VEC_W:0]    addr
);
   tv_code_t low;
   assign low  = promo ? '0 : code;
   assign vec  = {base, low};
   assign addr = {base, low, 1'b0};
endmodule

// File: rtl/tv_prio_vec.sv
module tv_prio_vec import tv_pkg::*; #(
   parameter int SRC_CNT = 11,
   parameter int BASE_W  = 4,
   parameter bit ADJ_EN  = 1'b1,
   localparam int VEC_W  = BASE_W + TV_CODE_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [SRC_CNT-1:0] pend_i,
   input  logic [BASE_W-1:0]  base_i,
   input  logic [3:0]         adj_i,
   output logic               req_o,
   output logic [3:0]         sel_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic [VEC_W:0]     addr_o
);
   generate
      if (SRC_CNT < 1 || SRC_CNT > (1 << TV_CODE_W) - 1) begin : g_bad_cnt
         $error("tv_prio_vec: SRC_CNT must leave code 0 free");
      end
      if (BASE_W < 1) begin : g_bad_base
         $error("tv_prio_vec: BASE_W must be at least 1");
      end
   endgenerate

   logic             f_hit, p_hit;
   tv_code_t         f_code, w_code;
   logic [VEC_W-1:0] n_vec;
   logic [VEC_W:0]   n_addr;

   tv_fixed_pick #(.SRC_CNT(SRC_CNT)) u_pick (
      .pend (pend_i),
      .hit  (f_hit),
      .code (f_code)
   );

   tv_promote #(.SRC_CNT(SRC_CNT), .ADJ_EN(ADJ_EN)) u_promo (
      .pend (pend_i),
      .adj  (adj_i),
      .hit  (p_hit)
   );

   assign w_code = p_hit ? adj_i : f_code;

   tv_vec_form #(.BASE_W(BASE_W)) u_form (
      .base  (base_i),
      .code  (w_code),
      .promo (p_hit),
      .vec   (n_vec),
      .addr  (n_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         req_o  <= 1'b0;
         sel_o  <= '0;
         vec_o  <= '0;
         addr_o <= '0;
      end else begin
         req_o <= f_hit;
         if (f_hit) begin
            sel_o  <= w_code;
            vec_o  <= n_vec;
            addr_o <= n_addr;
         end
      end
   end
endmodule

// File: rtl/tv_prio_vec_chk.sv
module tv_prio_vec_chk import tv_pkg::*; #(
   parameter int SRC_CNT = 11,
   parameter int BASE_W  = 4,
   localparam int VEC_W  = BASE_W + TV_CODE_W,
   localparam int WX     = 1 << TV_CODE_W
) (
   input logic               clk,
   input logic               rst,
   input logic [SRC_CNT-1:0] pend_i,
   input logic [BASE_W-1:0]  base_i,
   input logic [3:0]         adj_i,
   input logic               req_o,
   input logic [3:0]         sel_o,
   input logic [VEC_W-1:0]   vec_o,
   input logic [VEC_W:0]     addr_o
);
   logic [WX-1:0] pend_x;
   assign pend_x = WX'({pend_i, 1'b0});

   assert_reset_zero_R1: assert property (@(posedge clk)
      rst |=> (!req_o && sel_o == '0 && vec_o == '0 && addr_o == '0));

   assert_req_up_R2: assert property (@(posedge clk) disable iff (rst)
      (|pend_i) |=> req_o);

   assert_req_down_R2: assert property (@(posedge clk) disable iff (rst)
      !(|pend_i) |=> !req_o);

   assert_code_range_R3: assert property (@(posedge clk) disable iff (rst)
      req_o |-> (sel_o != '0 && int'(sel_o) <= SRC_CNT));

   assert_base_nibble_R4: assert property (@(posedge clk) disable iff (rst)
      (|pend_i) |=> vec_o[VEC_W-1:TV_CODE_W] == $past(base_i));

   assert_addr_double_R5: assert property (@(posedge clk) disable iff (rst)
      addr_o == {vec_o, 1'b0});

   assert_promoted_R6: assert property (@(posedge clk) disable iff (rst)
      pend_x[adj_i] |=> (vec_o[TV_CODE_W-1:0] == '0 && sel_o == $past(adj_i)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !(|pend_i) |=> ($stable(sel_o) && $stable(vec_o) && $stable(addr_o)));
endmodule

bind tv_prio_vec tv_prio_vec_chk #(.SRC_CNT(SRC_CNT), .BASE_W(BASE_W)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .pend_i (pend_i),
   .base_i (base_i),
   .adj_i  (adj_i),
   .req_o  (req_o),
   .sel_o  (sel_o),
   .vec_o  (vec_o),
   .addr_o (addr_o)
);

// File: tb/sim_tv_prio_vec.sv
`timescale 1ns/1ps
module sim_tv_prio_vec;
   localparam int NS = 11;

   logic          clk = 1'b0;
   logic          rst;
   logic [NS-1:0] pend_i;
   logic [3:0]    base_i;
   logic [3:0]    adj_i;
   logic          req_o;
   logic [3:0]    sel_o;
   logic [7:0]    vec_o;
   logic [8:0]    addr_o;

   int checks = 0;
   int errors = 0;

   logic [3:0] m_sel = '0;
   logic [7:0] m_vec = '0;

   always #2.5 clk = ~clk;

   tv_prio_vec u0 (
      .clk    (clk),
      .rst    (rst),
      .pend_i (pend_i),
      .base_i (base_i),
      .adj_i  (adj_i),
      .req_o  (req_o),
      .sel_o  (sel_o),
      .vec_o  (vec_o),
      .addr_o (addr_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Apply one input set, then compare one clock later against the rules.
   task automatic apply(input logic [NS-1:0] p, input logic [3:0] b,
                        input logic [3:0] a, input string req);
      logic [3:0] win;
      logic       promo;
      @(negedge clk);
      pend_i = p;
      base_i = b;
      adj_i  = a;
      @(posedge clk);
      #1;
      promo = (a >= 4'd1) && (a <= 4'd11) && p[a - 4'd1];
      win   = 4'd0;
      for (int k = NS - 1; k >= 0; k--) if (p[k]) win = 4'(k + 1);
      if (p != '0) begin
         m_sel = promo ? a : win;
         m_vec = {b, (promo ? 4'd0 : win)};
      end
      chk({req, " req"}, int'(req_o), int'(p != '0));
      chk({req, " sel"}, int'(sel_o), int'(m_sel));
      chk({req, " vec"}, int'(vec_o), int'(m_vec));
      chk({req, " addr R5"}, int'(addr_o), int'(m_vec) * 2);
   endtask

   task automatic t_reset;
      rst = 1'b1; pend_i = '1; base_i = 4'hF; adj_i = 4'd3;
      repeat (2) @(posedge clk);
      #1;
      chk("R1 req", int'(req_o), 0);
      chk("R1 sel", int'(sel_o), 0);
      chk("R1 vec", int'(vec_o), 0);
      chk("R1 addr", int'(addr_o), 0);
      @(negedge clk);
      rst = 1'b0; pend_i = '0; adj_i = 4'd0;
   endtask

   task automatic t_single;
      for (int k = 0; k < NS; k++) apply(NS'(1) << k, 4'h4, 4'd0, "R3 R4 single");
   endtask

   task automatic t_order;
      apply('1, 4'h2, 4'd0, "R3 all");
      apply(11'b110_0000_0000, 4'h7, 4'd0, "R3 top two");
      apply(11'b001_0010_1000, 4'h1, 4'd0, "R3 mixed");
      apply(11'b100_0000_0001, 4'hA, 4'd0, "R3 ends");
   endtask

   task automatic t_addr;
      apply(11'b000_0010_0000, 4'h4, 4'd0, "R5 0x46");
      chk("R5 example", int'(addr_o), 'h8C);
      apply(11'b100_0000_0000, 4'hF, 4'd0, "R5 top");
      chk("R5 top value", int'(addr_o), 'h1F6);
   endtask

   task automatic t_promote;
      apply(11'b000_0010_0001, 4'h4, 4'd6, "R6 code6");
      chk("R6 vec 0x40", int'(vec_o), 'h40);
      chk("R6 addr 0x80", int'(addr_o), 'h80);
      apply('1, 4'h9, 4'd11, "R6 code11");
      apply(11'b000_0000_0001, 4'h3, 4'd1, "R6 code1");
   endtask

   task automatic t_inert;
      apply(11'b000_0000_1010, 4'h5, 4'd6, "R7 not pending");
      chk("R7 vec", int'(vec_o), 'h52);
      for (int a = 12; a < 16; a++) apply('1, 4'h6, 4'(a), "R7 range");
      apply(11'b010_0100_0000, 4'h6, 4'd0, "R7 zero");
   endtask

   task automatic t_hold;
      apply(11'b000_0100_0000, 4'hC, 4'd0, "R8 load");
      apply('0, 4'h1, 4'd7, "R8 idle");
      chk("R8 vec kept", int'(vec_o), 'hC7);
      apply('0, 4'h9, 4'd0, "R8 idle2");
      chk("R2 low", int'(req_o), 0);
   endtask

   initial begin
      t_reset;
      t_single;
      t_order;
      t_addr;
      t_promote;
      t_inert;
      t_hold;
      repeat (2) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule